// File: doc/BRIEF.md
# Shader Conditional-Block Sequencer

This block owns the program counter and the conditional control flow of a small vertex-shader style processor. It addresses a 512-word program memory through `pc` and receives the addressed 32-bit instruction word back in the same cycle. The opcode is taken from the top six bits of the word. A conditional-block instruction tests two comparison flags, produced elsewhere, against reference bits in the word. If the test passes, the block records a pending block end together with a resume address on a nested stack and carries on with the next word. If the test fails, the block jumps to the destination address. After every executed instruction the new PC is compared with the block end on top of the stack; on a match the PC moves to the resume address and the entry is popped.

A stop instruction halts the run. Pushing onto a full stack is a fault, and so is an opcode outside the set the processor knows. An external loop unit may take over the PC in any executed cycle. Its redirect has priority over the end-of-block check, which is skipped in that cycle.

The FSM has five states: `ST_IDLE` (after reset), `ST_RUN` (one instruction per cycle), `ST_DONE` (halted by the stop opcode), `ST_OVF` (stack overflow) and `ST_BADOP` (unknown opcode). The transitions are named as follows. *go* takes any state to `ST_RUN` when `start` is high. *stop* goes from `ST_RUN` to `ST_DONE`. *overflow* goes from `ST_RUN` to `ST_OVF`. *reject* goes from `ST_RUN` to `ST_BADOP`. *step* keeps `ST_RUN` in `ST_RUN`.

Top module: `ifseq_top`

## Requirements
- R1: After reset the block is idle with `pc` = 0 and an empty stack. A cycle with `start` high moves it to the running state with `pc` = 0 and the stack emptied, whatever state it was in before.
- R2: The opcode is bits 31:26. Opcode 0x22 halts the run: `done` rises, and `pc` holds the address of that word until the next `start`.
- R3: Opcode 0x28 with a true condition while the stack already holds 8 entries raises `ovf_err` and halts with `pc` left at that word.
- R4: For opcode 0x28 the condition mode is bits 23:22 and the reference bits are bit 24 (for `flag_x`) and bit 25 (for `flag_y`). The modes are: 0 is true when either flag equals its reference, 1 needs both to match, 2 tests X alone, 3 tests Y alone.
- R5: When the condition is true, the block pushes a block end equal to DEST (bits 21:10) and a resume address equal to DEST + NUM (NUM is bits 7:0), both taken modulo 512, and the PC advances by one.
- R6: When the condition is false, the PC is loaded with DEST modulo 512 and nothing is pushed.
- R7: After each executed instruction, if the stack is not empty and the next PC equals the top block end, the PC takes the top resume address and the entry is popped. This includes an entry pushed by that same instruction.
- R8: While `loop_jump` is high in an executed cycle, the PC is loaded with `loop_pc` and no entry is popped, even when the end-of-block test would match.
- R9: Opcodes below 0x20 and the opcodes 0x29, 0x2E and 0x2F simply advance the PC by one. Any other opcode that is neither 0x22 nor 0x28 raises `bad_op` and halts with `pc` held.
- R10: Outside the running state the instruction word, the flags and the loop hook are ignored: `pc` and the status outputs hold until `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run from address 0 |
| instr | input | 32 | Program word at `pc` |
| flag_x | input | 1 | Comparison flag X |
| flag_y | input | 1 | Comparison flag Y |
| loop_jump | input | 1 | Loop unit redirects the PC this cycle |
| loop_pc | input | PC_W | Loop redirect target |
| pc | output | PC_W | Program counter / memory address |
| busy | output | 1 | Running state |
| done | output | 1 | Halted by the stop opcode |
| ovf_err | output | 1 | Conditional-block stack overflow |
| bad_op | output | 1 | Unknown opcode seen |

## Verification
Two functions can fall in the same cycle. A taken conditional push can coincide with the end-of-block pop when the destination is the next address, so that the block is empty and the fresh entry is consumed at once. The loop redirect can also land on a cycle whose PC matches the top block end. The bench provokes the first case with a destination of PC+1 and the second by raising `loop_jump` one word before a block end. A behavioural queue model is compared with the design every cycle. The final halted address shows which of the two paths was taken.

// File: rtl/ifseq_pkg.sv
package ifseq_pkg;

    localparam logic [5:0] OP_END  = 6'h22;
    localparam logic [5:0] OP_IFC  = 6'h28;
    localparam logic [5:0] OP_LOOP = 6'h29;
    localparam logic [5:0] OP_CMPA = 6'h2E;
    localparam logic [5:0] OP_CMPB = 6'h2F;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RUN,
        ST_DONE,
        ST_OVF,
        ST_BADOP
    } seq_state_e;

    typedef enum logic [1:0] {
        CM_ANY   = 2'd0,
        CM_BOTH  = 2'd1,
        CM_XONLY = 2'd2,
        CM_YONLY = 2'd3
    } cond_mode_e;

    function automatic logic op_known(input logic [5:0] op);
        return (op < 6'h20) || (op == OP_END) || (op == OP_IFC) ||
               (op == OP_LOOP) || (op == OP_CMPA) || (op == OP_CMPB);
    endfunction

endpackage

// File: rtl/ifseq_cond.sv
module ifseq_cond
    import ifseq_pkg::*;
(
    input  cond_mode_e mode,
    input  logic       ref_x,
    input  logic       ref_y,
    input  logic       flag_x,
    input  logic       flag_y,
    output logic       taken
);
    logic hit_x, hit_y;

    assign hit_x = (flag_x == ref_x);
    assign hit_y = (flag_y == ref_y);

    always_comb begin
        unique case (mode)
            CM_ANY:   taken = hit_x | hit_y;
            CM_BOTH:  taken = hit_x & hit_y;
            CM_XONLY: taken = hit_x;
            CM_YONLY: taken = hit_y;
        endcase
    end
endmodule

// File: rtl/ifseq_stack.sv
module ifseq_stack #(
    parameter int DEPTH = 8,
    parameter int PC_W  = 9
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         push,
    input  logic                         pop,
    input  logic [PC_W-1:0]              push_end,
    input  logic [PC_W-1:0]              push_res,
    output logic [PC_W-1:0]              top_end,
    output logic [PC_W-1:0]              top_res,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [PC_W-1:0]  end_mem [DEPTH];
    logic [PC_W-1:0]  res_mem [DEPTH];
    logic [IDX_W-1:0] wr_idx, top_idx;

    assign wr_idx  = IDX_W'(count);
    assign top_idx = IDX_W'(count - CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (push && !pop) begin
            count <= count + CNT_W'(1);
        end else if (pop && !push) begin
            count <= count - CNT_W'(1);
        end
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    end_mem[g] <= '0;
                    res_mem[g] <= '0;
                end else if (push && !pop && !clr && wr_idx == IDX_W'(g)) begin
                    end_mem[g] <= push_end;
                    res_mem[g] <= push_res;
                end
            end
        end
    endgenerate

    assign top_end = end_mem[top_idx];
    assign top_res = res_mem[top_idx];
endmodule

// File: rtl/ifseq_top.sv
module ifseq_top
    import ifseq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int PC_W  = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [31:0]     instr,
    input  logic            flag_x,
    input  logic            flag_y,
    input  logic            loop_jump,
    input  logic [PC_W-1:0] loop_pc,
    output logic [PC_W-1:0] pc,
    output logic            busy,
    output logic            done,
    output logic            ovf_err,
    output logic            bad_op
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    seq_state_e       state_q, state_d;
    logic [PC_W-1:0]  pc_q, pc_d;

    logic [5:0]       opcode;
    logic             is_end, is_ifc, known, taken;
    logic [PC_W-1:0]  dest_pc, res_pc, step_pc, after_pc;
    logic [PC_W-1:0]  top_end, top_res, eff_end, eff_res;
    logic [CNT_W-1:0] stk_cnt;
    logic             stk_full, push_req, ovf_hit, eff_nz, end_hit;
    logic             push, pop;
    logic             unused_bits;

    assign opcode      = instr[31:26];
    assign is_end      = (opcode == OP_END);
    assign is_ifc      = (opcode == OP_IFC);
    assign known       = op_known(opcode);
    assign dest_pc     = PC_W'(instr[21:10]);
    assign res_pc      = PC_W'({1'b0, instr[21:10]} + 13'(instr[7:0]));
    assign unused_bits = ^instr[9:8];

    ifseq_cond i_cond (
        .mode   (cond_mode_e'(instr[23:22])),
        .ref_x  (instr[24]),
        .ref_y  (instr[25]),
        .flag_x (flag_x),
        .flag_y (flag_y),
        .taken  (taken)
    );

    ifseq_stack #(.DEPTH(DEPTH), .PC_W(PC_W)) i_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (start),
        .push     (push),
        .pop      (pop),
        .push_end (dest_pc),
        .push_res (res_pc),
        .top_end  (top_end),
        .top_res  (top_res),
        .count    (stk_cnt)
    );

    // Decode of one instruction: advance, branch, push, end-of-block match
    assign stk_full = (stk_cnt == FULL);
    assign push_req = is_ifc && taken && !stk_full;
    assign ovf_hit  = is_ifc && taken && stk_full;
    assign step_pc  = pc_q + PC_W'(1);
    assign after_pc = (is_ifc && !taken) ? dest_pc : step_pc;
    assign eff_nz   = push_req || (stk_cnt != '0);
    assign eff_end  = push_req ? dest_pc : top_end;
    assign eff_res  = push_req ? res_pc  : top_res;
    assign end_hit  = eff_nz && (after_pc == eff_end);

    always_comb begin
        state_d = state_q;
        pc_d    = pc_q;
        push    = 1'b0;
        pop     = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (is_end) begin
                    state_d = ST_DONE;                 // stop
                end else if (!known) begin
                    state_d = ST_BADOP;                // reject
                end else if (ovf_hit) begin
                    state_d = ST_OVF;                  // overflow
                end else begin                         // step
                    push = push_req;
                    if (loop_jump) begin
                        pc_d = loop_pc;
                    end else if (end_hit) begin
                        pc_d = eff_res;
                        pop  = 1'b1;
                    end else begin
                        pc_d = after_pc;
                    end
                end
            end
            ST_IDLE, ST_DONE, ST_OVF, ST_BADOP: ;
        endcase
        if (start) begin                               // go
            state_d = ST_RUN;
            pc_d    = '0;
            push    = 1'b0;
            pop     = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pc_q    <= '0;
        end else begin
            state_q <= state_d;
            pc_q    <= pc_d;
        end
    end

    always_comb begin
        busy    = 1'b0;
        done    = 1'b0;
        ovf_err = 1'b0;
        bad_op  = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_RUN:   busy    = 1'b1;
            ST_DONE:  done    = 1'b1;
            ST_OVF:   ovf_err = 1'b1;
            ST_BADOP: bad_op  = 1'b1;
        endcase
    end

    assign pc = pc_q;
endmodule

// File: rtl/ifseq_chk.sv
module ifseq_chk #(
    parameter int DEPTH = 8,
    parameter int PC_W  = 9
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       start,
    input logic [PC_W-1:0]            pc,
    input logic                       busy,
    input logic                       done,
    input logic                       ovf_err,
    input logic                       bad_op,
    input logic [$clog2(DEPTH+1)-1:0] stk_cnt
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (pc == '0) && busy && (stk_cnt == '0));

    p_halt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done && $stable(pc));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_err) |-> ($past(stk_cnt) == FULL));

    p_depth_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stk_cnt <= FULL);

    p_one_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({busy, done, ovf_err, bad_op}));

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(pc) && !busy && $stable(stk_cnt));
endmodule

bind ifseq_top ifseq_chk #(.DEPTH(DEPTH), .PC_W(PC_W)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .pc      (pc),
    .busy    (busy),
    .done    (done),
    .ovf_err (ovf_err),
    .bad_op  (bad_op),
    .stk_cnt (stk_cnt)
);

// File: tb/test_ifseq_top.sv
module test_ifseq_top;
    localparam int PC_W = 9;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic            flag_x = 1'b0, flag_y = 1'b0;
    logic            loop_jump = 1'b0;
    logic [PC_W-1:0] loop_pc = '0;
    logic [31:0]     instr;
    logic [PC_W-1:0] pc;
    logic            busy, done, ovf_err, bad_op;
    logic [31:0]     prog [512];

    int n_chk = 0, n_fail = 0;
    int m_pc = 0, m_state = 0;     // 0 idle, 1 run, 2 done, 3 ovf, 4 badop
    int q_end[$], q_res[$];

    always #4 clk = ~clk;

    assign instr = prog[pc];

    ifseq_top #(.DEPTH(8), .PC_W(PC_W)) i_ifseq_top (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .flag_x(flag_x), .flag_y(flag_y), .loop_jump(loop_jump), .loop_pc(loop_pc),
        .pc(pc), .busy(busy), .done(done), .ovf_err(ovf_err), .bad_op(bad_op)
    );

    function automatic logic [31:0] w_ifc(int mode, int rx, int ry, int dest, int num);
        return {6'h28, 1'(ry), 1'(rx), 2'(mode), 12'(dest), 2'b00, 8'(num)};
    endfunction
    function automatic logic [31:0] w_op(int op);
        return {6'(op), 26'h0};
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        check("R7", "pc", int'(pc), m_pc);
        check("R1", "busy", int'(busy), int'(m_state == 1));
        check("R2", "done", int'(done), int'(m_state == 2));
        check("R3", "ovf_err", int'(ovf_err), int'(m_state == 3));
        check("R9", "bad_op", int'(bad_op), int'(m_state == 4));
    endtask

    function automatic bit unknown_op(int op);
        return op >= 'h20 && !(op == 'h22 || op == 'h28 || op == 'h29 || op == 'h2E || op == 'h2F);
    endfunction

    task automatic model_step(bit st, bit fx, bit fy, bit lj, int lpc);
        logic [31:0] w;
        int op, np;
        bit hx, hy, c;
        if (st) begin
            m_state = 1; m_pc = 0; q_end.delete(); q_res.delete();
            return;
        end
        if (m_state != 1) return;
        w  = prog[m_pc];
        op = int'(w[31:26]);
        if (op == 'h22) begin m_state = 2; return; end
        if (unknown_op(op)) begin m_state = 4; return; end
        np = m_pc + 1;
        if (op == 'h28) begin
            hx = (fx == w[24]); hy = (fy == w[25]);
            case (int'(w[23:22]))
                0: c = hx || hy;
                1: c = hx && hy;
                2: c = hx;
                default: c = hy;
            endcase
            if (c && q_end.size() == 8) begin m_state = 3; return; end
            if (c) begin
                q_end.push_back(int'(w[21:10]) % 512);
                q_res.push_back((int'(w[21:10]) + int'(w[7:0])) % 512);
            end else begin
                np = int'(w[21:10]);
            end
        end
        np = np % 512;
        if (lj) np = lpc;
        else if (q_end.size() > 0 && np == q_end[$]) begin
            np = q_res[$];
            void'(q_end.pop_back());
            void'(q_res.pop_back());
        end
        m_pc = np;
    endtask

    task automatic cyc(bit st, bit fx, bit fy, bit lj, int lpc);
        @(negedge clk);
        compare_all();
        start = st; flag_x = fx; flag_y = fy; loop_jump = lj; loop_pc = PC_W'(lpc);
        model_step(st, fx, fy, lj, lpc);
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 512; i++) prog[i] = w_op('h01);
    endtask

    task automatic run(bit fx, bit fy, int lj_at, int lpc);
        cyc(1'b1, fx, fy, 1'b0, 0);
        for (int i = 0; i < 600; i++) begin
            if (m_state != 1) break;
            cyc(1'b0, fx, fy, (m_pc == lj_at), lpc);
        end
        cyc(1'b0, fx, fy, 1'b0, 0);
    endtask

    // Block program: taken path halts at 5, untaken at 4
    task automatic load_block(int mode, int rx, int ry);
        clear_prog();
        prog[0] = w_ifc(mode, rx, ry, 3, 2);
        prog[4] = w_op('h22);
        prog[5] = w_op('h22);
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        clear_prog();
        repeat (3) cyc(1'b0, 1'b0, 1'b0, 1'b0, 0);
        rst_n = 1'b1;
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 0);
        check("R1", "reset pc", int'(pc), 0);
        check("R1", "reset idle", int'(busy | done), 0);

        // R2: plain ops then stop
        clear_prog(); prog[2] = w_op('h22);
        run(0, 0, -1, 0);
        check("R2", "stop pc", int'(pc), 2);
        check("R2", "done", int'(done), 1);

        // R10: halted state ignores word, flags and loop hook
        prog[2] = w_op('h30);
        for (int i = 0; i < 4; i++) cyc(1'b0, 1'b1, 1'b1, 1'b1, 7);
        check("R10", "pc held", int'(pc), 2);
        check("R10", "no bad_op", int'(bad_op), 0);

        // R5 / R7: taken block skipped tail
        load_block(2, 1, 0); run(1, 0, -1, 0);
        check("R5", "taken resume", int'(pc), 5);
        // R6: not taken jumps to DEST
        load_block(2, 1, 0); run(0, 0, -1, 0);
        check("R6", "untaken dest", int'(pc), 4);

        // R4: mode table
        load_block(0, 1, 1); run(0, 0, -1, 0);
        check("R4", "any no match", int'(pc), 4);
        load_block(0, 1, 1); run(1, 0, -1, 0);
        check("R4", "any x match", int'(pc), 5);
        load_block(1, 1, 1); run(1, 0, -1, 0);
        check("R4", "both one match", int'(pc), 4);
        load_block(1, 1, 1); run(1, 1, -1, 0);
        check("R4", "both match", int'(pc), 5);
        load_block(3, 1, 0); run(1, 0, -1, 0);
        check("R4", "y only", int'(pc), 5);
        load_block(3, 1, 1); run(1, 0, -1, 0);
        check("R4", "y only miss", int'(pc), 4);

        // R7: empty block, push and pop in the same cycle
        clear_prog();
        prog[0] = w_ifc(2, 1, 0, 1, 3);
        prog[1] = w_op('h30); prog[2] = w_op('h30); prog[3] = w_op('h30);
        prog[4] = w_op('h22);
        run(1, 0, -1, 0);
        check("R7", "same-cycle pop", int'(pc), 4);
        check("R7", "no bad_op", int'(bad_op), 0);

        // R7: nested blocks
        clear_prog();
        prog[0] = w_ifc(2, 1, 0, 5, 1);
        prog[1] = w_ifc(2, 1, 0, 3, 1);
        prog[3] = w_op('h30); prog[5] = w_op('h30);
        prog[6] = w_op('h22);
        run(1, 0, -1, 0);
        check("R7", "nested", int'(pc), 6);

        // R8: loop hook wins over end-of-block match
        clear_prog();
        prog[0] = w_ifc(2, 1, 0, 2, 3);
        prog[2] = w_op('h22);
        prog[5] = w_op('h22);
        run(1, 0, 1, 2);
        check("R8", "loop priority", int'(pc), 2);

        // R3: ninth push overflows
        clear_prog();
        for (int i = 0; i < 9; i++) prog[i] = w_ifc(2, 1, 0, 100, 0);
        run(1, 0, -1, 0);
        check("R3", "ovf_err", int'(ovf_err), 1);
        check("R3", "ovf pc", int'(pc), 8);

        // R9: known extra opcodes advance, unknown faults
        clear_prog();
        prog[0] = w_op('h2E); prog[1] = w_op('h29); prog[2] = w_op('h2F);
        prog[3] = w_op('h3A);
        run(0, 0, -1, 0);
        check("R9", "bad_op", int'(bad_op), 1);
        check("R9", "bad pc", int'(pc), 3);

        // R1: restart from fault clears state
        clear_prog(); prog[1] = w_op('h22);
        run(0, 0, -1, 0);
        check("R1", "restart", int'(pc), 1);
        check("R1", "restart done", int'(done), 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule